// File: doc/BRIEF.md
# Two-Phase Page DMA Engine

This block moves one fixed-size page (512 bytes by default) between a byte-wide flash data stream and system memory, with an on-chip page buffer in between. Each transfer has two phases. The flash phase moves the page between the flash stream and the buffer. The host phase moves it between the buffer and memory as 32-bit beats. The direction bit sets what each phase does. When data flows toward the host, the flash phase fills the buffer and the host phase writes memory. When data flows toward the flash, the host phase reads memory into the buffer and the flash phase then drains it.

Software programs a page-aligned base address. It then writes the control register with the direction bit and one phase-select bit, and that write starts the phase. The end of each phase sets its own status bit. An error sets a third status bit. Status bits are cleared by writing ones to them. The interrupt line is the OR of the status bits gated by their enables. Writing zero to the control register stops any active phase at once. If both select bits are set, the flash phase runs.

Top module: `pdma_top`

## Requirements
- R1: After reset the control (offset 0), base (1), enable (2) and status (3) registers read zero, `irq` is low, and `fin_ready`, `fout_valid` and `mem_valid` are low.
- R2: Control value 3'b011 (bit0 = toward host, bit1 = flash phase) accepts exactly 512 bytes on `fin_valid`/`fin_ready` into buffer bytes 0..511 in order. The last accepted byte sets status bit0 (flash done) and drops `fin_ready`.
- R3: Control value 3'b101 (bit2 = host phase, toward host) issues 128 write beats (`mem_write`=1). Beat k carries address base+4k and buffer bytes 4k..4k+3, with byte 4k in bits 7:0. The 128th accepted beat sets status bit1 (host done) and drops `mem_valid`.
- R4: Toward the flash, control 3'b100 issues 128 read beats (`mem_write`=0) whose `mem_rdata` fills the buffer. Control 3'b010 then presents the 512 buffer bytes in order on `fout_valid`/`fout_data`. Each phase sets its own done bit.
- R5: The base register drops the low 9 address bits on write: writing 0x12345FFF reads back 0x12345E00.
- R6: Writing the status register clears exactly the bits written as one and leaves the others set.
- R7: `irq` is high exactly when some status bit is set and its enable bit (same position in the enable register) is set.
- R8: A beat accepted with `mem_err` high sets status bit2 (error), sets no done bit and ends the phase, so `mem_valid` is low in the following cycle.
- R9: A nonzero control write with neither select bit (bits 2:1 zero) sets status bit2 and starts no transfer.
- R10: Writing zero to the control register during a phase stops it in the next cycle without setting any status bit.
- R11: The capability register (offset 4) reads 0x3. Both capability bits are set, so DMA is usable.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Interrupt request |
| fin_valid | input | 1 | Flash byte available (toward host) |
| fin_data | input | 8 | Flash byte in |
| fin_ready | output | 1 | Engine accepts a flash byte |
| fout_valid | output | 1 | Byte available for flash (toward flash) |
| fout_data | output | 8 | Byte out to flash |
| fout_ready | input | 1 | Flash side accepts the byte |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Beat accepted; rdata and err valid with it |
| mem_rdata | input | 32 | Read beat data |
| mem_err | input | 1 | Error response for the accepted beat |

## Verification
The bench stalls both streams at irregular points. A design that advanced its counter on valid alone would then drop or repeat bytes and beats, and would move the address while a beat is held. The last byte and the last beat are checked for the done bit. An off-by-one counter would finish a beat early or hang. The bench also checks the lane order inside each word, which catches swapped bytes in both directions. Error responses, selects-missing commands, mid-phase aborts and partial write-one-to-clear patterns are each checked against status and `irq`. A design that set a done bit on error, kept requesting after an abort or cleared unwritten status bits fails these checks.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] RA_BASE = 3'd1;
    localparam logic [REG_AW-1:0] RA_IEN  = 3'd2;
    localparam logic [REG_AW-1:0] RA_ISR  = 3'd3;
    localparam logic [REG_AW-1:0] RA_CAPS = 3'd4;

    // control word: bit0 toward host, bit1 flash phase, bit2 host phase
    typedef struct packed {
        logic sel_host;
        logic sel_flash;
        logic to_host;
    } ctrl_t;

    // status / enable bit layout
    typedef struct packed {
        logic err;
        logic host_done;
        logic flash_done;
    } irqv_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FLASH = 2'd1,
        PH_HOST  = 2'd2
    } phase_e;

    function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] l);
        return w[8*l +: 8];
    endfunction

endpackage

// File: rtl/pdma_pagebuf.sv
module pdma_pagebuf #(
    parameter int WORDS = 128,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [3:0]    be,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] ridx,
    output logic [31:0]   rdata
);
    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];
        always_ff @(posedge clk) begin
            if (we && be[b]) lane_mem[widx] <= wdata[8*b +: 8];
        end
        assign rdata[8*b +: 8] = lane_mem[ridx];
    end
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_BYTES = 512,
    parameter logic [1:0] CAPS = 2'b11,
    localparam int ALIGN_W = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  irqv_t             ev,
    output logic              cmd_valid,
    output ctrl_t             cmd,
    output logic [ADDR_W-1:0] base,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] base_q;
    irqv_t             ien_q;
    irqv_t             isr_q;
    irqv_t             w1c;

    assign cmd_valid = cfg_we && (cfg_addr == RA_CTRL);
    assign cmd       = ctrl_t'(cfg_wdata[2:0]);
    assign w1c       = (cfg_we && cfg_addr == RA_ISR) ? irqv_t'(cfg_wdata[2:0]) : irqv_t'(3'b000);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            ien_q  <= '0;
            isr_q  <= '0;
        end else begin
            if (cmd_valid) ctrl_q <= cmd;
            if (cfg_we && cfg_addr == RA_BASE)
                base_q <= {cfg_wdata[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
            if (cfg_we && cfg_addr == RA_IEN) ien_q <= irqv_t'(cfg_wdata[2:0]);
            isr_q <= (isr_q & ~w1c) | ev;
        end
    end

    assign base = base_q;
    assign irq  = |(isr_q & ien_q);

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_CTRL: cfg_rdata[2:0]        = ctrl_q;
            RA_BASE: cfg_rdata[ADDR_W-1:0] = base_q;
            RA_IEN:  cfg_rdata[2:0]        = ien_q;
            RA_ISR:  cfg_rdata[2:0]        = isr_q;
            RA_CAPS: cfg_rdata[1:0]        = CAPS;
            default: cfg_rdata             = '0;
        endcase
    end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_BYTES = 512,
    parameter bit USABLE = 1'b1,
    localparam int BEATS = PAGE_BYTES / 4,
    localparam int CNT_W = $clog2(PAGE_BYTES),
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  ctrl_t             cmd,
    input  logic [ADDR_W-1:0] base,
    input  logic              fin_valid,
    input  logic [7:0]        fin_data,
    output logic              fin_ready,
    output logic              fout_valid,
    output logic [7:0]        fout_data,
    input  logic              fout_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              buf_we,
    output logic [BEAT_W-1:0] buf_widx,
    output logic [3:0]        buf_be,
    output logic [31:0]       buf_wdata,
    output logic [BEAT_W-1:0] buf_ridx,
    input  logic [31:0]       buf_rdata,
    output irqv_t             ev
);
    phase_e           phase_q;
    logic             to_host_q;
    logic [CNT_W-1:0] cnt_q;

    logic flash_step, mem_fire, last_byte, last_beat, no_sel;

    assign fin_ready  = (phase_q == PH_FLASH) && to_host_q;
    assign fout_valid = (phase_q == PH_FLASH) && !to_host_q;
    assign mem_valid  = (phase_q == PH_HOST);
    assign mem_write  = to_host_q;

    assign flash_step = !cmd_valid && ((fin_ready && fin_valid) || (fout_valid && fout_ready));
    assign mem_fire   = !cmd_valid && mem_valid && mem_ready;
    assign last_byte  = (cnt_q == CNT_W'(PAGE_BYTES - 1));
    assign last_beat  = (cnt_q[BEAT_W-1:0] == BEAT_W'(BEATS - 1));
    assign no_sel     = !cmd.sel_flash && !cmd.sel_host;

    assign ev.flash_done = flash_step && last_byte;
    assign ev.host_done  = mem_fire && !mem_err && last_beat;
    assign ev.err        = (mem_fire && mem_err) || (cmd_valid && (cmd != '0) && no_sel);

    assign buf_ridx  = (phase_q == PH_FLASH) ? cnt_q[CNT_W-1:2] : cnt_q[BEAT_W-1:0];
    assign fout_data = lane_pick(buf_rdata, cnt_q[1:0]);
    assign mem_wdata = buf_rdata;
    assign mem_addr  = base + ADDR_W'({cnt_q[BEAT_W-1:0], 2'b00});

    always_comb begin
        buf_we    = 1'b0;
        buf_widx  = cnt_q[BEAT_W-1:0];
        buf_be    = 4'hF;
        buf_wdata = mem_rdata;
        if (phase_q == PH_FLASH) begin
            buf_we    = flash_step && to_host_q;
            buf_widx  = cnt_q[CNT_W-1:2];
            buf_be    = 4'b0001 << cnt_q[1:0];
            buf_wdata = {4{fin_data}};
        end else if (phase_q == PH_HOST) begin
            buf_we    = mem_fire && !mem_err && !to_host_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            to_host_q <= 1'b0;
            cnt_q     <= '0;
        end else if (cmd_valid) begin
            cnt_q     <= '0;
            to_host_q <= cmd.to_host;
            if (USABLE && cmd.sel_flash)     phase_q <= PH_FLASH;
            else if (USABLE && cmd.sel_host) phase_q <= PH_HOST;
            else                             phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_FLASH: if (flash_step) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_byte) phase_q <= PH_IDLE;
                end
                PH_HOST: if (mem_fire) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mem_err || last_beat) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pdma_top.sv
module pdma_top
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_BYTES = 512,
    parameter logic [1:0] CAPS = 2'b11,
    localparam int BEATS = PAGE_BYTES / 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    input  logic              fin_valid,
    input  logic [7:0]        fin_data,
    output logic              fin_ready,
    output logic              fout_valid,
    output logic [7:0]        fout_data,
    input  logic              fout_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err
);
    logic              cmd_valid;
    ctrl_t             cmd;
    logic [ADDR_W-1:0] base;
    irqv_t             ev_w;
    logic              buf_we;
    logic [BEAT_W-1:0] buf_widx, buf_ridx;
    logic [3:0]        buf_be;
    logic [31:0]       buf_wdata, buf_rdata;

    pdma_regs #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CAPS(CAPS)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev(ev_w),
        .cmd_valid(cmd_valid), .cmd(cmd), .base(base), .irq(irq)
    );

    pdma_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .USABLE(&CAPS)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .base(base),
        .fin_valid(fin_valid), .fin_data(fin_data), .fin_ready(fin_ready),
        .fout_valid(fout_valid), .fout_data(fout_data), .fout_ready(fout_ready),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .buf_we(buf_we), .buf_widx(buf_widx), .buf_be(buf_be),
        .buf_wdata(buf_wdata), .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .ev(ev_w)
    );

    pdma_pagebuf #(.WORDS(BEATS)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_widx), .be(buf_be),
        .wdata(buf_wdata), .ridx(buf_ridx), .rdata(buf_rdata)
    );
endmodule

// File: rtl/pdma_chk.sv
module pdma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [2:0]        cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              fin_ready,
    input logic              fout_valid,
    input logic              fout_ready,
    input logic [7:0]        fout_data,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [2:0]        ev
);
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready && !cfg_we) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

    a_r4_fout_hold: assert property (@(posedge clk) disable iff (rst)
        (fout_valid && !fout_ready && !cfg_we) |=> (fout_valid && $stable(fout_data)));

    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 3'd0 && cfg_wdata[2:0] == 3'b000) |=> (!mem_valid && !fin_ready && !fout_valid));

    a_r8_err_ends_phase: assert property (@(posedge clk) disable iff (rst)
        ev[2] |=> (!mem_valid && !fin_ready && !fout_valid));

    a_r3_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev));

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));
endmodule

bind pdma_top pdma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fin_ready(fin_ready), .fout_valid(fout_valid), .fout_ready(fout_ready),
    .fout_data(fout_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ev(ev_w)
);

// File: tb/sim_pdma_top.sv
module sim_pdma_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        fin_valid = 1'b0;
    logic [7:0]  fin_data = '0;
    logic        fin_ready;
    logic        fout_valid;
    logic [7:0]  fout_data;
    logic        fout_ready = 1'b0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pdma_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq), .fin_valid(fin_valid), .fin_data(fin_data),
        .fin_ready(fin_ready), .fout_valid(fout_valid), .fout_data(fout_data),
        .fout_ready(fout_ready), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    function automatic logic [7:0] fpat(input int i);
        return 8'((i * 13 + 7) ^ (i >> 3));
    endfunction

    function automatic logic [31:0] fword(input int k);
        return {fpat(4*k+3), fpat(4*k+2), fpat(4*k+1), fpat(4*k)};
    endfunction

    function automatic logic [31:0] wpat(input int k);
        return 32'hA500_0000 ^ (32'(k) * 32'h0103_0507);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic feed_flash(input int n, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (i % 41 == 9) begin @(negedge clk); fin_valid = 1'b0; end
            @(negedge clk);
            fin_valid = 1'b1; fin_data = fpat(i);
            if (!fin_ready) begin bad++; break; end
        end
        @(negedge clk);
        fin_valid = 1'b0;
    endtask

    task automatic host_phase(input bit to_host, input logic [31:0] base, input int err_at,
                              output int bad, output int hold_bad, output int beats);
        logic [31:0] prev_addr;
        bit prev_stall;
        int k = 0;
        bad = 0; hold_bad = 0; prev_stall = 1'b0; prev_addr = '0;
        for (int g = 0; g < 2000 && k < 128; g++) begin
            @(negedge clk);
            if (!mem_valid) break;
            if (prev_stall && mem_addr != prev_addr) hold_bad++;
            if (mem_addr != base + 32'(4*k) || mem_write != to_host) bad++;
            if (to_host && mem_wdata != fword(k)) bad++;
            mem_ready = (g % 3 != 1);
            mem_rdata = wpat(k);
            mem_err   = mem_ready && (k == err_at);
            prev_stall = !mem_ready;
            prev_addr  = mem_addr;
            if (mem_ready) begin
                k++;
                if (mem_err) break;
            end
        end
        beats = k;
        @(negedge clk);
        mem_ready = 1'b0; mem_err = 1'b0;
    endtask

    task automatic drain_flash(output int bad, output int got);
        int j = 0;
        bad = 0;
        for (int g = 0; g < 4000 && j < 512; g++) begin
            @(negedge clk);
            if (!fout_valid) break;
            fout_ready = (g % 5 != 2);
            if (fout_ready) begin
                if (fout_data != wpat(j / 4)[8*(j%4) +: 8]) bad++;
                j++;
            end
        end
        got = j;
        @(negedge clk);
        fout_ready = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(3'd1, d); chk(d == 0, "R1 base", d, 0);
        rd(3'd2, d); chk(d == 0, "R1 enable", d, 0);
        rd(3'd3, d); chk(d == 0, "R1 status", d, 0);
        chk({irq, fin_ready, fout_valid, mem_valid} == 0, "R1 outputs",
            {irq, fin_ready, fout_valid, mem_valid}, 0);
        rd(3'd4, d); chk(d == 32'h3, "R11 caps", d, 32'h3);
    endtask

    task automatic t_align;
        logic [31:0] d;
        wr(3'd1, 32'h1234_5FFF);
        rd(3'd1, d); chk(d == 32'h1234_5E00, "R5 base align", d, 32'h1234_5E00);
    endtask

    task automatic t_to_host;
        logic [31:0] d;
        int bad, hb, n;
        wr(3'd0, 32'b011);
        feed_flash(512, bad);
        chk(bad == 0, "R2 flash bytes accepted", 32'(bad), 0);
        rd(3'd3, d); chk(d == 32'h1, "R2 flash done", d, 32'h1);
        chk(fin_ready == 0, "R2 idle after page", {31'b0, fin_ready}, 0);
        chk(irq == 0, "R7 masked irq", {31'b0, irq}, 0);
        wr(3'd3, 32'h1);
        rd(3'd3, d); chk(d == 0, "R6 clear flash done", d, 0);
        wr(3'd0, 32'b101);
        host_phase(1'b1, 32'h1234_5E00, -1, bad, hb, n);
        chk(bad == 0, "R3 beat addr/data", 32'(bad), 0);
        chk(n == 128, "R3 beat count", 32'(n), 128);
        chk(hb == 0, "R12 addr hold", 32'(hb), 0);
        chk(mem_valid == 0, "R3 idle after page", {31'b0, mem_valid}, 0);
        rd(3'd3, d); chk(d == 32'h2, "R3 host done", d, 32'h2);
    endtask

    task automatic t_irq_w1c;
        logic [31:0] d;
        wr(3'd2, 32'h2);
        chk(irq == 1, "R7 enabled irq", {31'b0, irq}, 1);
        wr(3'd2, 32'h5);
        chk(irq == 0, "R7 other enables", {31'b0, irq}, 0);
        wr(3'd3, 32'h5);
        rd(3'd3, d); chk(d == 32'h2, "R6 partial clear", d, 32'h2);
        wr(3'd3, 32'h2);
        rd(3'd3, d); chk(d == 0, "R6 full clear", d, 0);
    endtask

    task automatic t_to_flash;
        logic [31:0] d;
        int bad, hb, n;
        wr(3'd1, 32'h0000_4000);
        wr(3'd0, 32'b100);
        host_phase(1'b0, 32'h0000_4000, -1, bad, hb, n);
        chk(bad == 0 && n == 128, "R4 read beats", 32'(n), 128);
        rd(3'd3, d); chk(d == 32'h2, "R4 host done", d, 32'h2);
        wr(3'd3, 32'h7);
        wr(3'd0, 32'b010);
        drain_flash(bad, n);
        chk(n == 512, "R4 flash byte count", 32'(n), 512);
        chk(bad == 0, "R4 flash byte order", 32'(bad), 0);
        chk(fout_valid == 0, "R4 idle after page", {31'b0, fout_valid}, 0);
        rd(3'd3, d); chk(d == 32'h1, "R4 flash done", d, 32'h1);
        wr(3'd3, 32'h7);
    endtask

    task automatic t_mem_error;
        logic [31:0] d;
        int bad, hb, n;
        wr(3'd2, 32'h4);
        wr(3'd0, 32'b101);
        host_phase(1'b1, 32'h0000_4000, 10, bad, hb, n);
        chk(n == 11, "R8 beats before error", 32'(n), 11);
        chk(mem_valid == 0, "R8 phase ended", {31'b0, mem_valid}, 0);
        rd(3'd3, d); chk(d == 32'h4, "R8 error status only", d, 32'h4);
        chk(irq == 1, "R7 error irq", {31'b0, irq}, 1);
        wr(3'd3, 32'h4);
        chk(irq == 0, "R7 irq drops on clear", {31'b0, irq}, 0);
    endtask

    task automatic t_no_select;
        logic [31:0] d;
        wr(3'd0, 32'b001);
        chk({mem_valid, fin_ready, fout_valid} == 0, "R9 no transfer",
            {29'b0, mem_valid, fin_ready, fout_valid}, 0);
        rd(3'd3, d); chk(d == 32'h4, "R9 error status", d, 32'h4);
        wr(3'd3, 32'h4);
    endtask

    task automatic t_abort;
        logic [31:0] d;
        int bad;
        wr(3'd0, 32'b011);
        feed_flash(20, bad);
        chk(fin_ready == 1, "R10 phase active", {31'b0, fin_ready}, 1);
        wr(3'd0, 32'b000);
        chk(fin_ready == 0, "R10 stopped", {31'b0, fin_ready}, 0);
        rd(3'd3, d); chk(d == 0, "R10 no status", d, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_align();
        t_to_host();
        t_irq_w1c();
        t_to_flash();
        t_mem_error();
        t_no_select();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule